// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the transmit side of a frame-synchronised serial port. Software places data words into a small store. With the store in single-word mode it acts as one holding register, and with queue mode enabled it is an eight-entry first-in first-out queue. A start condition, qualified by the port enable and the transmitter enable, moves the oldest stored word into a shift register. The word is then sent most significant bit first on a serial data pin. One bit goes out per bit-time strobe. The pin's output enable is high only while a word is on the wire. Outside that window the pad is released.

The bit clock and the frame sync are produced elsewhere and arrive as inputs. A single-cycle strobe `bit_en` marks each bit time. In continuous-clock timing, the start condition is the first bit time at which frame sync is seen high. This covers a late frame sync held high for the whole word. In gated-clock timing, the start condition is the first bit strobe after the gated clock starts running. Empty flags feed a masked interrupt request, and the flags used depend on the store mode. Sticky flags record an underrun and a write into a full store.

Top module: `sfx_transmitter`

## Requirements
- R1: After reset, `txd_oe` and `txd` are 0, `fifo_level` is 0, and `f_underrun`, `f_wr_ovf` and `irq` are 0.
- R2: A start condition is ignored unless `port_en` and `tx_en` are both 1. When ignored, the stored word stays in place (`fifo_level` is unchanged) and `txd_oe` stays 0.
- R3: Continuous-clock timing (`gated`=0): a word starts at the bit strobe where `fsync` is 1 and was 0 at the previous strobe. The word's MSB is on `txd` from the next clock edge. If `fsync` stays high for the rest of the word, no restart occurs.
- R4: Gated-clock timing (`gated`=1): a word starts at the first `bit_en` strobe after `clk_run` has risen. When `clk_run` falls, the pin is released within one clock.
- R5: A word is `wlen_m1`+1 bits long (1 to 16). It is taken from bits `wlen_m1`..0 of the written value and sent most significant bit first. Bits above `wlen_m1` have no effect.
- R6: `txd_oe` is 1 for exactly the word's bit times and 0 otherwise. `txd` is 0 whenever `txd_oe` is 0.
- R7: A new start condition at the strobe right after a word's last bit loads the next word with no gap, so `txd_oe` stays 1.
- R8: `f_data_empty` is 1 when queue mode is off and the store is empty. `f_fifo_empty` is 1 when queue mode is on and the store is empty. They are never 1 together.
- R9: `irq` = `tie` AND ((`f_data_empty` AND `msk_data_empty`) OR (`f_fifo_empty` AND `msk_fifo_empty`)).
- R10: The store holds 8 words with `fifo_en`=1 and 1 word with `fifo_en`=0. Words leave in the order they were written, and eight queued words go out without further writes.
- R11: A write while the store is full, with no word leaving in that cycle, is dropped and sets sticky `f_wr_ovf`. A pulse on `ov_clr` clears `f_wr_ovf`.
- R12: Suppose a start condition occurs with no stored word, after at least one word has been sent since the enables were last both set. Then a word of zeros is sent and sticky `f_underrun` is set, and a pulse on `ur_clr` clears it. Before the first word after enabling, such a start does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmitter enable |
| fifo_en | input | 1 | 1: eight-word queue, 0: single holding word |
| gated | input | 1 | 1: gated-clock timing, 0: continuous-clock timing |
| wlen_m1 | input | 4 | Word length minus one |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 16 | Word to store, right-aligned |
| tie | input | 1 | Global transmit interrupt enable |
| msk_data_empty | input | 1 | Interrupt mask for `f_data_empty` |
| msk_fifo_empty | input | 1 | Interrupt mask for `f_fifo_empty` |
| ur_clr | input | 1 | Clear pulse for `f_underrun` |
| ov_clr | input | 1 | Clear pulse for `f_wr_ovf` |
| bit_en | input | 1 | One-cycle strobe per bit time |
| fsync | input | 1 | Frame sync level, sampled at `bit_en` |
| clk_run | input | 1 | High while the gated bit clock runs |
| txd | output | 1 | Serial data |
| txd_oe | output | 1 | Pad output enable for `txd` |
| f_data_empty | output | 1 | Holding word empty (queue off) |
| f_fifo_empty | output | 1 | Queue empty (queue on) |
| f_underrun | output | 1 | Sticky underrun flag |
| f_wr_ovf | output | 1 | Sticky dropped-write flag |
| irq | output | 1 | Masked transmit interrupt request |
| fifo_level | output | 4 | Number of stored words |

## Verification
A wrong bit counter or shift register shows up on `txd` within the word it corrupts. A wrong counter also moves the edge of `txd_oe`, so the window is one bit time too short or too long. A corrupted store pointer or level shows up as `fifo_level` drifting from the writes and sends, or as words leaving out of order. That shows at the next send, or at most eight words later. A wrong start decision shows at the same clock edge as the strobe: a frame appears while disabled, fails to appear, or restarts under a held frame sync. Broken flag logic shows on `irq` in the same cycle, because the request is combinational from the flags.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  // Place a right-aligned word of len_m1+1 bits at the top of a maxw-bit field.
  function automatic logic [31:0] left_justify(input logic [31:0] w,
                                               input int unsigned len_m1,
                                               input int unsigned maxw);
    return w << (maxw - 1 - len_m1);
  endfunction

  // Usable store capacity for the selected mode.
  function automatic int unsigned store_cap(input logic queue_on,
                                            input int unsigned depth);
    return queue_on ? depth : 1;
  endfunction

  // Ring pointer advance for any depth.
  function automatic int unsigned ring_next(input int unsigned p,
                                            input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          queue_on,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          reject
);
  import sfx_pkg::*;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap;
  logic          full, do_rd, accept;

  assign cap    = CW'(store_cap(queue_on, DEPTH));
  assign full   = (cnt >= cap);
  assign empty  = (cnt == '0);
  assign do_rd  = rd && !empty;
  assign accept = wr && (!full || do_rd);
  assign reject = wr && !accept;
  assign rdata  = mem[rp];
  assign level  = cnt;

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= AW'(ring_next(32'(wp), DEPTH));
      if (do_rd)  rp <= AW'(ring_next(32'(rp), DEPTH));
      case ({accept, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sfx_trigger.sv
module sfx_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic fsync,
  input  logic clk_run,
  input  logic gated,
  output logic trig
);
  logic fs_q;      // frame sync at the previous bit strobe
  logic started;   // a bit strobe has been seen in the current gated run

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q    <= 1'b0;
      started <= 1'b0;
    end else begin
      if (bit_en) fs_q <= fsync;
      started <= clk_run ? (started | bit_en) : 1'b0;
    end
  end

  always_comb begin
    if (gated) trig = bit_en && clk_run && !started;
    else       trig = bit_en && fsync && !fs_q;
  end
endmodule

// File: rtl/sfx_shifter.sv
module sfx_shifter #(
  parameter int MAXW = 16,
  localparam int LW  = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            load,
  input  logic            halt,
  input  logic [MAXW-1:0] word,
  input  logic [LW-1:0]   len_m1,
  output logic            sd,
  output logic            oe
);
  logic [MAXW-1:0] sh;
  logic [LW-1:0]   left;
  logic            busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
      busy <= 1'b0;
    end else if (bit_en && load) begin
      sh   <= word;
      left <= len_m1;
      busy <= 1'b1;
    end else if (halt) begin
      busy <= 1'b0;
    end else if (bit_en && busy) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        sh   <= sh << 1;
        left <= left - 1'b1;
      end
    end
  end

  assign sd = busy & sh[MAXW-1];
  assign oe = busy;
endmodule

// File: rtl/sfx_transmitter.sv
module sfx_transmitter #(
  parameter int MAXW  = 16,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(MAXW),
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic            tx_en,
  input  logic            fifo_en,
  input  logic            gated,
  input  logic [LW-1:0]   wlen_m1,
  input  logic            wr_en,
  input  logic [MAXW-1:0] wr_data,
  input  logic            tie,
  input  logic            msk_data_empty,
  input  logic            msk_fifo_empty,
  input  logic            ur_clr,
  input  logic            ov_clr,
  input  logic            bit_en,
  input  logic            fsync,
  input  logic            clk_run,
  output logic            txd,
  output logic            txd_oe,
  output logic            f_data_empty,
  output logic            f_fifo_empty,
  output logic            f_underrun,
  output logic            f_wr_ovf,
  output logic            irq,
  output logic [LVW-1:0]  fifo_level
);
  import sfx_pkg::*;

  // Named internal events, also observed by the bound checker.
  logic            trig, start, pop, urun_evt, ovf_evt, primed, empty, halt;
  logic [MAXW-1:0] head, head_just, load_word;

  sfx_fifo #(.W(MAXW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .queue_on (fifo_en),
    .wr       (wr_en),
    .wdata    (wr_data),
    .rd       (pop),
    .rdata    (head),
    .level    (fifo_level),
    .empty    (empty),
    .reject   (ovf_evt)
  );

  sfx_trigger u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .fsync   (fsync),
    .clk_run (clk_run),
    .gated   (gated),
    .trig    (trig)
  );

  assign start    = trig && port_en && tx_en && (!empty || primed);
  assign pop      = start && !empty;
  assign urun_evt = start && empty;
  assign halt     = gated && !clk_run;

  assign head_just = MAXW'(left_justify(32'(head), 32'(wlen_m1), MAXW));
  assign load_word = empty ? '0 : head_just;

  sfx_shifter #(.MAXW(MAXW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .load   (start),
    .halt   (halt),
    .word   (load_word),
    .len_m1 (wlen_m1),
    .sd     (txd),
    .oe     (txd_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed     <= 1'b0;
      f_underrun <= 1'b0;
      f_wr_ovf   <= 1'b0;
    end else begin
      if (!(port_en && tx_en)) primed <= 1'b0;
      else if (pop)            primed <= 1'b1;
      if (urun_evt)    f_underrun <= 1'b1;
      else if (ur_clr) f_underrun <= 1'b0;
      if (ovf_evt)     f_wr_ovf <= 1'b1;
      else if (ov_clr) f_wr_ovf <= 1'b0;
    end
  end

  assign f_data_empty = !fifo_en && empty;
  assign f_fifo_empty =  fifo_en && empty;
  assign irq = tie && ((f_data_empty && msk_data_empty) ||
                       (f_fifo_empty && msk_fifo_empty));
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker #(
  parameter int DEPTH = 8,
  parameter int LVW   = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           port_en,
  input logic           tx_en,
  input logic           bit_en,
  input logic           tie,
  input logic           txd,
  input logic           txd_oe,
  input logic           irq,
  input logic           f_underrun,
  input logic           f_wr_ovf,
  input logic           f_data_empty,
  input logic           f_fifo_empty,
  input logic [LVW-1:0] fifo_level,
  input logic           pop,
  input logic           urun_evt,
  input logic           ovf_evt
);
  assert_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !txd_oe |-> !txd);

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (port_en && tx_en));

  assert_oe_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txd_oe) |-> $past(bit_en));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> f_wr_ovf);

  assert_drop_keeps_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (fifo_level == $past(fifo_level)));

  assert_underrun_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    urun_evt |=> f_underrun);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tie);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_data_empty && f_fifo_empty));

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVW'(DEPTH));
endmodule

bind sfx_transmitter sfx_checker #(.DEPTH(DEPTH), .LVW(LVW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .port_en      (port_en),
  .tx_en        (tx_en),
  .bit_en       (bit_en),
  .tie          (tie),
  .txd          (txd),
  .txd_oe       (txd_oe),
  .irq          (irq),
  .f_underrun   (f_underrun),
  .f_wr_ovf     (f_wr_ovf),
  .f_data_empty (f_data_empty),
  .f_fifo_empty (f_fifo_empty),
  .fifo_level   (fifo_level),
  .pop          (pop),
  .urun_evt     (urun_evt),
  .ovf_evt      (ovf_evt)
);

// File: tb/sim_sfx_transmitter.sv
`timescale 1ns/1ps
module sim_sfx_transmitter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b1, tx_en = 1'b1, fifo_en = 1'b0, gated = 1'b0;
  logic [3:0] wlen_m1 = 4'd7;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic tie = 1'b0, msk_data_empty = 1'b0, msk_fifo_empty = 1'b0;
  logic ur_clr = 1'b0, ov_clr = 1'b0;
  logic bit_en = 1'b0, fsync = 1'b0, clk_run = 1'b0;
  logic txd, txd_oe, f_data_empty, f_fifo_empty, f_underrun, f_wr_ovf, irq;
  logic [3:0] fifo_level;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;   // 50 MHz

  sfx_transmitter u0 (.*);

  // {gated, wlen_m1, written value}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 4'd7,  16'h00A5},
    {1'b1, 4'd7,  16'h003C},
    {1'b0, 4'd15, 16'hBEEF},
    {1'b1, 4'd15, 16'h8001},
    {1'b0, 4'd7,  16'hFF5A},
    {1'b1, 4'd0,  16'h0001},
    {1'b0, 4'd11, 16'h0ABC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] low_bits(input logic [15:0] d, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = d[i];
    return r;
  endfunction

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_clr(input logic which_ovf);
    @(negedge clk); if (which_ovf) ov_clr = 1'b1; else ur_clr = 1'b1;
    @(negedge clk); ov_clr = 1'b0; ur_clr = 1'b0;
  endtask

  // One bit time; outputs are sampled by the caller right after return.
  task automatic tick(input logic f, input logic r);
    @(negedge clk); bit_en = 1'b1; fsync = f; clk_run = r;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic run_frame(input logic g, input int n, output logic [15:0] bits,
                           output logic oe_all, output logic oe_after);
    bits = '0; oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      tick(!g, g);
      bits = {bits[14:0], txd};
      oe_all = oe_all & txd_oe;
    end
    if (g) begin
      @(negedge clk); clk_run = 1'b0;
      @(negedge clk);
    end else begin
      tick(1'b0, 1'b0);
    end
    oe_after = txd_oe;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] bits;
    logic oe_all, oe_after;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd_oe", 32'(txd_oe), 0);
    chk("R1 txd", 32'(txd), 0);
    chk("R1 level", 32'(fifo_level), 0);
    chk("R1 sticky", 32'({f_underrun, f_wr_ovf}), 0);
    chk("R1 irq", 32'(irq), 0);

    // R8/R9 flag and interrupt routing
    tie = 1'b1; msk_data_empty = 1'b1; #1;
    chk("R8 data_empty", 32'({f_data_empty, f_fifo_empty}), 32'b10);
    chk("R9 irq data_empty", 32'(irq), 1);
    msk_data_empty = 1'b0; msk_fifo_empty = 1'b1; #1;
    chk("R9 irq wrong mask", 32'(irq), 0);
    fifo_en = 1'b1; #1;
    chk("R8 fifo_empty", 32'({f_data_empty, f_fifo_empty}), 32'b01);
    chk("R9 irq fifo_empty", 32'(irq), 1);
    wr(16'h00C3);
    chk("R9 irq not empty", 32'(irq), 0);
    tie = 1'b0; msk_fifo_empty = 1'b0;
    run_frame(1'b0, 8, bits, oe_all, oe_after);
    chk("R5 queued word", 32'(bits), 32'h00C3);
    fifo_en = 1'b0;

    // Table walk: R3 R4 R5 R6
    foreach (VEC[k]) begin
      gated = VEC[k][20];
      wlen_m1 = VEC[k][19:16];
      wr(VEC[k][15:0]);
      run_frame(gated, int'(wlen_m1) + 1, bits, oe_all, oe_after);
      chk(gated ? "R4 R5 bits gated" : "R3 R5 bits continuous", 32'(bits),
          32'(low_bits(VEC[k][15:0], int'(wlen_m1) + 1)));
      chk("R6 oe window", 32'({oe_all, oe_after}), 32'b10);
    end
    gated = 1'b0; wlen_m1 = 4'd7;

    // R2 disabled port ignores start
    port_en = 1'b0;
    wr(16'h0066);
    tick(1'b1, 1'b0);
    chk("R2 oe while disabled", 32'(txd_oe), 0);
    tick(1'b0, 1'b0);
    chk("R2 level kept", 32'(fifo_level), 1);
    port_en = 1'b1;
    run_frame(1'b0, 8, bits, oe_all, oe_after);
    chk("R2 word after enable", 32'(bits), 32'h66);

    // R10/R11 queue depth, order, dropped write
    fifo_en = 1'b1;
    for (int k = 0; k < 9; k++) wr(16'(16'h10 + k));
    chk("R10 level full", 32'(fifo_level), 8);
    chk("R11 ovf set", 32'(f_wr_ovf), 1);
    for (int k = 0; k < 8; k++) begin
      run_frame(1'b0, 8, bits, oe_all, oe_after);
      chk("R10 order", 32'(bits), 32'(16'h10 + k));
    end
    chk("R10 drained", 32'({fifo_level, f_fifo_empty}), 32'h01);
    pulse_clr(1'b1);
    chk("R11 ovf cleared", 32'(f_wr_ovf), 0);

    // R10/R11 single-word store
    fifo_en = 1'b0;
    wr(16'h0011); wr(16'h0022);
    chk("R10 single cap", 32'(fifo_level), 1);
    chk("R11 ovf single", 32'(f_wr_ovf), 1);
    run_frame(1'b0, 8, bits, oe_all, oe_after);
    chk("R11 first kept", 32'(bits), 32'h11);
    pulse_clr(1'b1);

    // R7 back-to-back words, 4 bits each
    fifo_en = 1'b1; wlen_m1 = 4'd3;
    wr(16'h000A); wr(16'h0005);
    bits = '0; oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick((i % 4) == 0, 1'b0);
      bits = {bits[14:0], txd};
      oe_all = oe_all & txd_oe;
    end
    tick(1'b0, 1'b0);
    chk("R7 seamless bits", 32'(bits), 32'hA5);
    chk("R7 oe held then off", 32'({oe_all, txd_oe}), 32'b10);
    wlen_m1 = 4'd7;

    // R12 underrun after a word has gone out
    run_frame(1'b0, 8, bits, oe_all, oe_after);
    chk("R12 zeros driven", 32'({bits, oe_all}), 32'h1);
    chk("R12 underrun set", 32'(f_underrun), 1);
    pulse_clr(1'b0);
    chk("R12 underrun cleared", 32'(f_underrun), 0);
    // R12 no send before the first word after enabling
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    tick(1'b1, 1'b0);
    chk("R12 unprimed oe", 32'(txd_oe), 0);
    tick(1'b0, 1'b0);
    chk("R12 unprimed flag", 32'(f_underrun), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule